// File: doc/BRIEF.md
# Process-Tagged Translation Entry Flush Scanner

This block walks every entry of two translation lookaside arrays (an instruction array and a data array, each organised as ways by indices) after a software-style flush command names a process tag. It reads each entry through a synchronous read port owned by the storage. It then decides whether the entry belongs to the named process. For each entry that does, it hands a page invalidation request, carrying the page's virtual address, to a downstream consumer over a valid/ready handshake.

The scan is a single pass over both arrays. Backpressure from the consumer slows the walk and never drops an entry. A one-cycle completion pulse tells the requester that every owned page has been handed off. The block does not own the storage, and it does not perform the invalidation itself.

Top module: `tlb_pid_sweep`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_en_o` and `flush_valid_o` are all low.
- R2: A start pulse accepted while idle captures only bits 7:0 of `pid_i` as the flush tag; the upper bits of `pid_i` have no effect on which entries are flushed.
- R3: Each scan reads every entry exactly once, in order of the read address `{rd_unit_o, rd_way_o, rd_idx_o}` counting from 0 to 127: array 0 before array 1, ways 0 to 3 within an array, indices 0 to 15 within a way.
- R4: Entry contents are taken from `rd_hi_i`/`rd_lo_i` in the clock cycle that follows a cycle with `rd_en_o` high.
- R5: An entry yields a flush request if and only if low word bit 3 (present) is 1, low word bit 4 (shared across processes) is 0, and high word bits 7:0 equal the captured tag.
- R6: The request address `flush_vaddr_o` is high word bits 31:13 followed by 13 zero bits.
- R7: Requests leave in scan order; while `flush_valid_o` is high and `flush_ready_i` is low, the request stays valid with an unchanged address, and no matching entry is skipped.
- R8: `done_o` is high for exactly one cycle, in the first cycle in which `busy_o` is low after a scan, and only after the last entry has been examined and its request, if any, has been accepted.
- R9: A start pulse received while `busy_o` is high is ignored: the tag, the read sequence and the request stream of the running scan are unchanged, and no second scan follows.
- R10: While `busy_o` is low, `rd_en_o` and `flush_valid_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a scan (single-cycle pulse) |
| pid_i | input | 32 | Flush tag; only bits 7:0 are used |
| busy_o | output | 1 | A scan is in progress |
| done_o | output | 1 | One-cycle pulse at scan completion |
| rd_en_o | output | 1 | Read request to entry storage |
| rd_unit_o | output | 1 | Array select of the read (0 instruction, 1 data) |
| rd_way_o | output | 2 | Way of the read |
| rd_idx_o | output | 4 | Index of the read |
| rd_hi_i | input | 32 | Entry high word, valid one cycle after the read |
| rd_lo_i | input | 32 | Entry low word, valid one cycle after the read |
| flush_valid_o | output | 1 | Page invalidation request valid |
| flush_ready_i | input | 1 | Consumer accepts the request |
| flush_vaddr_o | output | 32 | Virtual address of the page to invalidate |

## Verification
The assertions watch the cycle-level rules on every clock: the held request under backpressure, that a pending request is never overwritten, that the read counter starts at zero and stops after a single pass, that the block stays silent while idle, that a late start leaves the tag untouched, and that the completion pulse is one cycle long and coincides with the fall of busy. The selection rule, the address rebuild, the complete ordered set of requests and the exact read sequence can only be shown by the bench's scans. These scans compare every handed-off address against a list computed from the entry contents, under always-ready, randomly stalling and heavily stalling consumers. They cover directed patterns that separate each field of the rule, and they include tags that differ only in their upper bits.

// File: rtl/tlbfs_pkg.sv
package tlbfs_pkg;

  // Field positions inside an entry; the selection logic depends on them.
  localparam int unsigned LO_PRESENT_BIT = 3;
  localparam int unsigned LO_SHARED_BIT  = 4;
  localparam int unsigned HI_TAG_LSB     = 0;

  typedef enum logic [0:0] {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_state_e;

  function automatic int unsigned field_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tlbfs_walker.sv
module tlbfs_walker #(
  parameter int unsigned N_UNITS = 2,
  parameter int unsigned N_WAYS  = 4,
  parameter int unsigned N_IDX   = 16,
  localparam int unsigned UNIT_W = tlbfs_pkg::field_w(N_UNITS),
  localparam int unsigned WAY_W  = tlbfs_pkg::field_w(N_WAYS),
  localparam int unsigned IDX_W  = tlbfs_pkg::field_w(N_IDX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              issue_i,
  output logic [UNIT_W-1:0] unit_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              exhausted_o
);

  localparam int unsigned CNT_W = UNIT_W + WAY_W + IDX_W;
  localparam int unsigned TOTAL = N_UNITS * N_WAYS * N_IDX;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] pos_q, pos_d;
  logic             ex_q, ex_d;
  logic             at_last;

  assign at_last = (pos_q == LAST_POS);

  always_comb begin
    pos_d = pos_q;
    ex_d  = ex_q;
    if (launch_i) begin
      pos_d = '0;
      ex_d  = 1'b0;
    end else if (issue_i) begin
      if (at_last) begin
        ex_d = 1'b1;
      end else begin
        pos_d = pos_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      ex_q  <= 1'b0;
    end else begin
      if (launch_i || issue_i) begin
        pos_q <= pos_d;
        ex_q  <= ex_d;
      end
    end
  end

  // Linear position split into index (low), way, array (high).
  assign idx_o       = pos_q[IDX_W-1:0];
  assign way_o       = pos_q[IDX_W +: WAY_W];
  assign unit_o      = pos_q[IDX_W+WAY_W +: UNIT_W];
  assign exhausted_o = ex_q;

  assert_launch_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> (pos_q == '0) && !ex_q);

  assert_single_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_q |-> !issue_i);

endmodule

// File: rtl/tlbfs_match.sv
module tlbfs_match #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned TAG_W      = 8,
  parameter int unsigned PAGE_SHIFT = 13
) (
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] vaddr_o
);

  import tlbfs_pkg::*;

  logic present, shared, tag_eq;

  assign present = lo_i[LO_PRESENT_BIT];
  assign shared  = lo_i[LO_SHARED_BIT];
  assign tag_eq  = (hi_i[HI_TAG_LSB +: TAG_W] == tag_i);
  assign hit_o   = present && !shared && tag_eq;

  generate
    if (PAGE_SHIFT > 0) begin : g_page_offset
      assign vaddr_o = {hi_i[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end else begin : g_no_offset
      assign vaddr_o = hi_i;
    end
  endgenerate

endmodule

// File: rtl/tlbfs_emit.sv
module tlbfs_emit #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] vaddr_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] vaddr_o
);

  logic              vld_q, vld_d;
  logic [WORD_W-1:0] va_q, va_d;
  logic              va_en;

  always_comb begin
    vld_d = vld_q;
    va_d  = va_q;
    va_en = 1'b0;
    if (load_i) begin
      vld_d = 1'b1;
      va_d  = vaddr_i;
      va_en = 1'b1;
    end else if (vld_q && ready_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q <= '0;
    end else if (va_en) begin
      va_q <= va_d;
    end
  end

  assign valid_o = vld_q;
  assign vaddr_o = va_q;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !ready_i) |=> vld_q && $stable(va_q));

  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!vld_q || ready_i));

endmodule

// File: rtl/tlb_pid_sweep.sv
module tlb_pid_sweep #(
  parameter int unsigned N_UNITS    = 2,
  parameter int unsigned N_WAYS     = 4,
  parameter int unsigned N_IDX      = 16,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned REQ_W      = 32,
  parameter int unsigned TAG_W      = 8,
  parameter int unsigned PAGE_SHIFT = 13,
  localparam int unsigned UNIT_W = tlbfs_pkg::field_w(N_UNITS),
  localparam int unsigned WAY_W  = tlbfs_pkg::field_w(N_WAYS),
  localparam int unsigned IDX_W  = tlbfs_pkg::field_w(N_IDX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [REQ_W-1:0]  pid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [UNIT_W-1:0] rd_unit_o,
  output logic [WAY_W-1:0]  rd_way_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [WORD_W-1:0] rd_hi_i,
  input  logic [WORD_W-1:0] rd_lo_i,
  output logic              flush_valid_o,
  input  logic              flush_ready_i,
  output logic [WORD_W-1:0] flush_vaddr_o
);

  import tlbfs_pkg::*;

  sweep_state_e      st_q, st_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic              rsp_q, rsp_d;
  logic              done_q, done_d;

  logic              launch, issue, exhausted, finish;
  logic              hit, load, slot_taken;
  logic [WORD_W-1:0] hit_va;

  // Accept a start only while idle; the tag is cut to its low bits.
  assign launch = start_i && (st_q == SWEEP_IDLE);

  // The response of an issued read lands next cycle; issue only if the
  // output slot is guaranteed free to take it.
  assign slot_taken = (flush_valid_o && !flush_ready_i) || (rsp_q && hit);
  assign issue      = (st_q == SWEEP_RUN) && !exhausted && !slot_taken;
  assign load       = rsp_q && hit;
  assign finish     = (st_q == SWEEP_RUN) && exhausted && !rsp_q &&
                      (!flush_valid_o || flush_ready_i);

  always_comb begin
    st_d   = st_q;
    tag_d  = tag_q;
    rsp_d  = issue;
    done_d = 1'b0;
    if (launch) begin
      st_d  = SWEEP_RUN;
      tag_d = pid_i[TAG_W-1:0];
    end else if (finish) begin
      st_d   = SWEEP_IDLE;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SWEEP_IDLE;
      rsp_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rsp_q  <= rsp_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (launch) begin
      tag_q <= tag_d;
    end
  end

  tlbfs_walker #(
    .N_UNITS (N_UNITS),
    .N_WAYS  (N_WAYS),
    .N_IDX   (N_IDX)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (launch),
    .issue_i     (issue),
    .unit_o      (rd_unit_o),
    .way_o       (rd_way_o),
    .idx_o       (rd_idx_o),
    .exhausted_o (exhausted)
  );

  tlbfs_match #(
    .WORD_W     (WORD_W),
    .TAG_W      (TAG_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_match (
    .hi_i    (rd_hi_i),
    .lo_i    (rd_lo_i),
    .tag_i   (tag_q),
    .hit_o   (hit),
    .vaddr_o (hit_va)
  );

  tlbfs_emit #(
    .WORD_W (WORD_W)
  ) u_emit (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .vaddr_i (hit_va),
    .ready_i (flush_ready_i),
    .valid_o (flush_valid_o),
    .vaddr_o (flush_vaddr_o)
  );

  assign busy_o  = (st_q == SWEEP_RUN);
  assign done_o  = done_q;
  assign rd_en_o = issue;

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_en_o && !flush_valid_o);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> busy_o && $stable(tag_q));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_with_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_rsp_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> busy_o && !finish);

endmodule

// File: tb/tlb_pid_sweep_bench.sv
module tlb_pid_sweep_bench;

  localparam int TOTAL = 128;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] pid_i;
  logic        busy_o, done_o, rd_en_o;
  logic [0:0]  rd_unit_o;
  logic [1:0]  rd_way_o;
  logic [3:0]  rd_idx_o;
  logic [31:0] rd_hi_i, rd_lo_i;
  logic        flush_valid_o, flush_ready_i;
  logic [31:0] flush_vaddr_o;

  logic [31:0] hi_mem [TOTAL];
  logic [31:0] lo_mem [TOTAL];
  logic [31:0] exp_va [TOTAL];
  int          exp_n, got_n, rd_seq, done_n;
  int          checks, fails;
  int          ready_mode;
  logic        prev_stall;
  logic [31:0] prev_va;

  tlb_pid_sweep u_tlb_pid_sweep (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .pid_i         (pid_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .rd_en_o       (rd_en_o),
    .rd_unit_o     (rd_unit_o),
    .rd_way_o      (rd_way_o),
    .rd_idx_o      (rd_idx_o),
    .rd_hi_i       (rd_hi_i),
    .rd_lo_i       (rd_lo_i),
    .flush_valid_o (flush_valid_o),
    .flush_ready_i (flush_ready_i),
    .flush_vaddr_o (flush_vaddr_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Storage model with one cycle of read latency (R4).
  always @(posedge clk) begin
    if (rd_en_o) begin
      rd_hi_i <= hi_mem[{rd_unit_o, rd_way_o, rd_idx_o}];
      rd_lo_i <= lo_mem[{rd_unit_o, rd_way_o, rd_idx_o}];
    end
  end

  initial begin
    #(4 * 200000);
    $display("FAIL watchdog: run did not end, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit sel(input logic [31:0] hi, input logic [31:0] lo,
                             input logic [7:0] tag);
    return lo[3] && !lo[4] && (hi[7:0] == tag);
  endfunction

  function automatic logic [31:0] page_of(input logic [31:0] hi);
    return {hi[31:13], 13'd0};
  endfunction

  task automatic build_expect(input logic [7:0] tag);
    exp_n = 0;
    for (int k = 0; k < TOTAL; k++) begin
      if (sel(hi_mem[k], lo_mem[k], tag)) begin
        exp_va[exp_n] = page_of(hi_mem[k]);
        exp_n++;
      end
    end
  endtask

  // One cycle: inputs change just after the rising edge, outputs are
  // observed at the falling edge.
  task automatic tick();
    @(posedge clk);
    #1;
    case (ready_mode)
      0:       flush_ready_i = 1'b1;
      1:       flush_ready_i = ($urandom % 2) == 0;
      default: flush_ready_i = ($urandom % 4) == 0;
    endcase
    @(negedge clk);
    if (rd_en_o) begin
      check({rd_unit_o, rd_way_o, rd_idx_o} == 7'(rd_seq), "R3 read order",
            32'({rd_unit_o, rd_way_o, rd_idx_o}), 32'(rd_seq));
      rd_seq++;
    end
    if (!busy_o) begin
      if (rd_en_o || flush_valid_o)
        check(1'b0, "R10 idle quiet", {30'd0, rd_en_o, flush_valid_o}, 32'd0);
    end
    if (flush_valid_o) begin
      if (prev_stall)
        check(flush_vaddr_o == prev_va, "R7 held address", flush_vaddr_o, prev_va);
      if (flush_ready_i) begin
        if (got_n < exp_n)
          check(flush_vaddr_o == exp_va[got_n], "R5/R6 request address",
                flush_vaddr_o, exp_va[got_n]);
        else
          check(1'b0, "R5 extra request", 32'(got_n + 1), 32'(exp_n));
        got_n++;
      end
    end
    prev_stall = flush_valid_o && !flush_ready_i;
    prev_va    = flush_vaddr_o;
    if (done_o) done_n++;
  endtask

  // kind 0 random, 1 directed per-field pattern, 2 all select, 3 none select
  task automatic fill(input int kind, input logic [7:0] tag);
    for (int k = 0; k < TOTAL; k++) begin
      logic [31:0] h, l;
      h = $urandom;
      l = $urandom;
      case (kind)
        0: if (($urandom % 3) == 0) h[7:0] = tag;
        1: begin
          h[7:0] = tag;
          l[3] = 1'b1;
          l[4] = 1'b0;
          case (k % 4)
            1: l[4] = 1'b1;
            2: l[3] = 1'b0;
            3: h[7:0] = tag ^ 8'h01;
            default: ;
          endcase
        end
        2: begin
          h[7:0] = tag;
          l[3] = 1'b1;
          l[4] = 1'b0;
        end
        default: if (h[7:0] == tag) h[7:0] = tag ^ 8'h80;
      endcase
      hi_mem[k] = h;
      lo_mem[k] = l;
    end
  endtask

  task automatic run_scan(input logic [31:0] req, input int mode, input bit late_start);
    int n;
    ready_mode = mode;
    build_expect(req[7:0]);   // R2: only the low 8 bits select
    rd_seq = 0;
    got_n  = 0;
    done_n = 0;
    prev_stall = 1'b0;
    start_i = 1'b1;
    pid_i   = req;
    tick();
    start_i = 1'b0;
    n = 0;
    while (done_n == 0 && n < 4000) begin
      tick();
      n++;
      if (late_start && n == 20) begin
        // R9: a second start with a different tag while busy
        start_i = 1'b1;
        pid_i   = ~req;
      end else begin
        start_i = 1'b0;
      end
    end
    check(done_n == 1, "R8 done seen once", 32'(done_n), 32'd1);
    check(!busy_o, "R8 busy low with done", {31'd0, busy_o}, 32'd0);
    check(got_n == exp_n, "R7 request count", 32'(got_n), 32'(exp_n));
    check(rd_seq == TOTAL, "R3 reads per scan", 32'(rd_seq), 32'(TOTAL));
    tick();
    check(!done_o, "R8 done one cycle", {31'd0, done_o}, 32'd0);
    check(!busy_o, "R9 no second scan", {31'd0, busy_o}, 32'd0);
    repeat (3) tick();
    check(rd_seq == TOTAL && got_n == exp_n, "R10 idle after scan",
          32'(rd_seq), 32'(TOTAL));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    checks = 0;
    fails  = 0;
    ready_mode = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    pid_i = '0;
    flush_ready_i = 1'b1;
    rd_hi_i = '0;
    rd_lo_i = '0;
    prev_stall = 1'b0;
    prev_va = '0;
    rd_seq = 0; got_n = 0; exp_n = 0; done_n = 0;
    for (int k = 0; k < TOTAL; k++) begin
      hi_mem[k] = '0;
      lo_mem[k] = '0;
    end
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !rd_en_o && !flush_valid_o, "R1 reset state",
          {28'd0, busy_o, done_o, rd_en_o, flush_valid_o}, 32'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    check(!busy_o && !done_o && !rd_en_o && !flush_valid_o, "R1 after release",
          {28'd0, busy_o, done_o, rd_en_o, flush_valid_o}, 32'd0);

    // Directed: each selection field exercised on its own (R5), upper tag bits set (R2)
    fill(1, 8'h3C);
    run_scan(32'hDEAD_BE3C, 0, 1'b0);
    fill(1, 8'h3C);
    run_scan(32'h0000_003C, 2, 1'b1);
    // Every entry selected under heavy backpressure (R7)
    fill(2, 8'hFF);
    run_scan(32'h1234_56FF, 2, 1'b0);
    // Nothing selected (R5)
    fill(3, 8'h00);
    run_scan(32'hFFFF_FF00, 1, 1'b1);
    // Random contents and consumers, late starts (R9)
    for (int s = 0; s < 6; s++) begin
      logic [31:0] r;
      r = $urandom;
      fill(0, r[7:0]);
      run_scan(r, s % 3, (s % 2) == 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule